// File: doc/BRIEF.md
# Trace Qualification Switch

This block decides, on every clock cycle, whether a core's trace unit may emit messages and which kinds. A host-owned master enable gates everything. Beneath it sits a sub-switch that event inputs steer. Eight execution-event match lines and eight data-event match lines arrive as decoded pulses. Each line carries its own role bits: set the section, clear the section, or hold a level-sensitive qualifier on.

The sub-switch is the OR of two parts. One is the latched section state. The other is the qualifier that the execution events drive in the current cycle. While the sub-switch is on, three independent selects allow program-flow, instrumentation and stack-access messages. Data-access messages follow per-event flags. A flag can arm an event for the sub-switch-on state, for the sub-switch-off state, or for both. All four enables are registered, so an event sampled at one clock edge shows on the outputs right after that edge.

Top module: `trace_gate_ctl`

## Requirements
- R1: While `host_en` is 0, all four enable outputs are 0 from the next clock edge, whatever the event, role and select inputs are.
- R2: With `host_en` held at 1, an execution or data hit whose on-role bit is 1 sets the section state. The enables selected by `sel_flow`, `sel_instr` and `sel_stack` then go to 1 at the next edge and stay at 1 after the hit ends.
- R3: With `host_en` held at 1, an execution or data hit whose off-role bit is 1 clears the section state. With no qualifier active, the flow, instrumentation and stack enables read 0 from the next edge.
- R4: If hits with the on-role and hits with the off-role occur in the same cycle, the section state ends cleared.
- R5: An execution hit whose qualify-role bit is 1 turns the sub-switch on only for the cycle in which it is asserted. The enables follow one edge later and fall back when the hit ends, unless the section state is set.
- R6: The sub-switch equals the section state (after this cycle's update) ORed with the qualifier. The flow, instrumentation and stack enables equal `host_en` AND sub-switch AND their own select.
- R7: `sel_flow`, `sel_instr` and `sel_stack` each gate only their own output.
- R8: `data_en` is 1 after an edge where `host_en`, `sel_data` and `data_strobe` were 1 and at least one data hit was valid for the sub-switch state. A hit is valid in the on state if its `data_qual_on` bit is 1, and valid in the off state if its `data_qual_off` bit is 1. Setting both bits makes a hit valid in either state. With `data_strobe` at 0, `data_en` is 0.
- R9: In the cycle where `host_en` goes from 0 to 1, the section state is cleared and on-role hits in that cycle are ignored. The qualifier still applies in that cycle.
- R10: `rst_n` is an active-low synchronous reset. It clears the section state, the stored previous `host_en`, and all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_en | input | 1 | Master trace enable from the host |
| exec_hit | input | N_EXEC | Execution event match pulses |
| exec_on_role | input | N_EXEC | Per execution event: hit sets the section |
| exec_off_role | input | N_EXEC | Per execution event: hit clears the section |
| exec_qual_role | input | N_EXEC | Per execution event: hit holds the qualifier on |
| data_hit | input | N_DATA | Data event match pulses |
| data_on_role | input | N_DATA | Per data event: hit sets the section |
| data_off_role | input | N_DATA | Per data event: hit clears the section |
| data_qual_on | input | N_DATA | Per data event: data messages allowed while sub-switch on |
| data_qual_off | input | N_DATA | Per data event: data messages allowed while sub-switch off |
| data_strobe | input | 1 | A data access is present this cycle |
| sel_flow | input | 1 | Select program-flow messages |
| sel_instr | input | 1 | Select instrumentation messages |
| sel_stack | input | 1 | Select stack-access messages |
| sel_data | input | 1 | Select qualified data-access messages |
| flow_en | output | 1 | Program-flow message enable |
| instr_en | output | 1 | Instrumentation message enable |
| stack_en | output | 1 | Stack-access message enable |
| data_en | output | 1 | Data-access message enable |

## Verification
The bench targets four cases:
- Simultaneous on-role and off-role hits. A design that lets set win leaves tracing running after a stop event.
- An on-role hit in the same cycle as the master enable rising. A design that takes it starts tracing with stale section state.
- A qualify hit followed by an idle cycle. A design that latches the qualifier never lets the enables fall.
- Data hits with only the off-state flag while the section is set, and with both flags. A design that decodes the flags against the wrong switch state emits data messages in exactly the window the user excluded.

// File: rtl/trace_gate_pkg.sv
// Shared types and default sizes for the trace qualification switch.
package trace_gate_pkg;
    parameter int unsigned N_EXEC_DEF = 8;
    parameter int unsigned N_DATA_DEF = 8;

    // One bit per message class enabled for the next cycle.
    typedef struct packed {
        logic flow;
        logic instr;
        logic stack;
        logic data;
    } trc_en_t;
endpackage

// File: rtl/trc_role_reduce.sv
// Reduces a set of event hit lines against one role mask.
// Assumes hits are already-decoded single-cycle pulses.
module trc_role_reduce #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] role,
    output logic         any
);
    logic [N-1:0] masked;

    // Per-event gating of the hit by its role bit.
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_mask
            assign masked[gi] = hit[gi] & role[gi];
        end
    endgenerate

    // Any event of this role is active.
    assign any = |masked;
endmodule

// File: rtl/trc_section_sw.sv
// Latched section switch. Holds while the master enable is off.
// Clears on the master enable's rising edge. Off requests beat on requests.
// Exposes the updated (next) value so the top can register outputs with one cycle of latency.
module trc_section_sw (
    input  logic clk,
    input  logic rst_n,
    input  logic host_en,
    input  logic set_req,
    input  logic clr_req,
    output logic sect_nxt
);
    logic sect_q;
    logic host_en_q;
    logic en_rise;

    assign en_rise = host_en & ~host_en_q;

    // Next-state selection in priority order.
    always_comb begin
        if (en_rise)       sect_nxt = 1'b0;
        else if (!host_en) sect_nxt = sect_q;
        else if (clr_req)  sect_nxt = 1'b0;
        else if (set_req)  sect_nxt = 1'b1;
        else               sect_nxt = sect_q;
    end

    // State and enable-edge history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sect_q    <= 1'b0;
            host_en_q <= 1'b0;
        end else begin
            sect_q    <= sect_nxt;
            host_en_q <= host_en;
        end
    end
endmodule

// File: rtl/trc_data_qual.sv
// Per-data-event qualification against the current sub-switch state.
// Assumes strobe marks the cycle that carries a data access.
module trc_data_qual #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] qual_on,
    input  logic [N-1:0] qual_off,
    input  logic         sub_on,
    input  logic         strobe,
    output logic         pass
);
    logic [N-1:0] ok;

    // Each event is valid if its flag matches the switch state.
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_evt
            assign ok[gi] = hit[gi] & ((qual_on[gi] & sub_on) | (qual_off[gi] & ~sub_on));
        end
    endgenerate

    // A strobed access with any valid event passes.
    assign pass = strobe & (|ok);
endmodule

// File: rtl/trace_gate_ctl.sv
// Trace qualification switch: the master enable and the event-driven sub-switch
// produce four registered message-class enables.
// Assumes event lines are decoded pulses synchronous to clk.
module trace_gate_ctl
    import trace_gate_pkg::*;
#(
    parameter int unsigned N_EXEC = N_EXEC_DEF,
    parameter int unsigned N_DATA = N_DATA_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic [N_EXEC-1:0] exec_hit,
    input  logic [N_EXEC-1:0] exec_on_role,
    input  logic [N_EXEC-1:0] exec_off_role,
    input  logic [N_EXEC-1:0] exec_qual_role,
    input  logic [N_DATA-1:0] data_hit,
    input  logic [N_DATA-1:0] data_on_role,
    input  logic [N_DATA-1:0] data_off_role,
    input  logic [N_DATA-1:0] data_qual_on,
    input  logic [N_DATA-1:0] data_qual_off,
    input  logic              data_strobe,
    input  logic              sel_flow,
    input  logic              sel_instr,
    input  logic              sel_stack,
    input  logic              sel_data,
    output logic              flow_en,
    output logic              instr_en,
    output logic              stack_en,
    output logic              data_en
);
    logic    x_on, x_off, x_qual, d_on, d_off;
    logic    sect_nxt, sub_on, data_pass;
    trc_en_t en_d, en_q;

    trc_role_reduce #(.N(N_EXEC)) u_x_on   (.hit(exec_hit), .role(exec_on_role),   .any(x_on));
    trc_role_reduce #(.N(N_EXEC)) u_x_off  (.hit(exec_hit), .role(exec_off_role),  .any(x_off));
    trc_role_reduce #(.N(N_EXEC)) u_x_qual (.hit(exec_hit), .role(exec_qual_role), .any(x_qual));
    trc_role_reduce #(.N(N_DATA)) u_d_on   (.hit(data_hit), .role(data_on_role),   .any(d_on));
    trc_role_reduce #(.N(N_DATA)) u_d_off  (.hit(data_hit), .role(data_off_role),  .any(d_off));

    trc_section_sw u_sect (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_en  (host_en),
        .set_req  (x_on | d_on),
        .clr_req  (x_off | d_off),
        .sect_nxt (sect_nxt)
    );

    assign sub_on = sect_nxt | x_qual;

    trc_data_qual #(.N(N_DATA)) u_dq (
        .hit      (data_hit),
        .qual_on  (data_qual_on),
        .qual_off (data_qual_off),
        .sub_on   (sub_on),
        .strobe   (data_strobe),
        .pass     (data_pass)
    );

    // Combine the master enable, the sub-switch and the class selects.
    always_comb begin
        en_d.flow  = host_en & sub_on & sel_flow;
        en_d.instr = host_en & sub_on & sel_instr;
        en_d.stack = host_en & sub_on & sel_stack;
        en_d.data  = host_en & sel_data & data_pass;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign flow_en  = en_q.flow;
    assign instr_en = en_q.instr;
    assign stack_en = en_q.stack;
    assign data_en  = en_q.data;
endmodule

// File: rtl/trace_gate_chk.sv
// Property checker for trace_gate_ctl, attached with bind.
// Keeps its own record of the previous master enable, reset to 0.
module trace_gate_chk #(
    parameter int unsigned N_EXEC = 8,
    parameter int unsigned N_DATA = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_en,
    input logic [N_EXEC-1:0] exec_hit,
    input logic [N_EXEC-1:0] exec_on_role,
    input logic [N_EXEC-1:0] exec_off_role,
    input logic [N_EXEC-1:0] exec_qual_role,
    input logic [N_DATA-1:0] data_hit,
    input logic [N_DATA-1:0] data_on_role,
    input logic [N_DATA-1:0] data_off_role,
    input logic [N_DATA-1:0] data_qual_on,
    input logic [N_DATA-1:0] data_qual_off,
    input logic              data_strobe,
    input logic              sel_flow,
    input logic              sel_data,
    input logic              flow_en,
    input logic              instr_en,
    input logic              stack_en,
    input logic              data_en
);
    logic prev_en;
    logic on_any, off_any, qual_any;

    assign on_any   = |(exec_hit & exec_on_role)  | |(data_hit & data_on_role);
    assign off_any  = |(exec_hit & exec_off_role) | |(data_hit & data_off_role);
    assign qual_any = |(exec_hit & exec_qual_role);

    // Record of the previous master enable.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_en <= 1'b0;
        else        prev_en <= host_en;
    end

    // R1
    host_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en |=> !(flow_en | instr_en | stack_en | data_en));

    // R2
    on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && prev_en && on_any && !off_any && sel_flow |=> flow_en);

    // R4
    off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && prev_en && off_any && !qual_any |=> !(flow_en | instr_en | stack_en));

    // R5
    qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && qual_any && sel_flow |=> flow_en);

    // R9
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && !prev_en && !qual_any |=> !(flow_en | instr_en | stack_en));

    // R8
    data_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && sel_data && data_strobe && (|(data_hit & data_qual_on & data_qual_off)) |=> data_en);

    // R8
    data_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_strobe |=> !data_en);
endmodule

bind trace_gate_ctl trace_gate_chk #(.N_EXEC(N_EXEC), .N_DATA(N_DATA)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_en        (host_en),
    .exec_hit       (exec_hit),
    .exec_on_role   (exec_on_role),
    .exec_off_role  (exec_off_role),
    .exec_qual_role (exec_qual_role),
    .data_hit       (data_hit),
    .data_on_role   (data_on_role),
    .data_off_role  (data_off_role),
    .data_qual_on   (data_qual_on),
    .data_qual_off  (data_qual_off),
    .data_strobe    (data_strobe),
    .sel_flow       (sel_flow),
    .sel_data       (sel_data),
    .flow_en        (flow_en),
    .instr_en       (instr_en),
    .stack_en       (stack_en),
    .data_en        (data_en)
);

// File: tb/trace_gate_ctl_bench.sv
`timescale 1ns/1ps
module trace_gate_ctl_bench;
    localparam int NE = 8;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_en;
    logic [NE-1:0] exec_hit, exec_on_role, exec_off_role, exec_qual_role;
    logic [ND-1:0] data_hit, data_on_role, data_off_role, data_qual_on, data_qual_off;
    logic          data_strobe, sel_flow, sel_instr, sel_stack, sel_data;
    logic          flow_en, instr_en, stack_en, data_en;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // Reference state.
    logic m_sect, m_prev;
    logic e_flow, e_instr, e_stack, e_data;

    always #10 clk = ~clk;

    trace_gate_ctl u_trace_gate_ctl (
        .clk(clk), .rst_n(rst_n), .host_en(host_en),
        .exec_hit(exec_hit), .exec_on_role(exec_on_role),
        .exec_off_role(exec_off_role), .exec_qual_role(exec_qual_role),
        .data_hit(data_hit), .data_on_role(data_on_role),
        .data_off_role(data_off_role), .data_qual_on(data_qual_on),
        .data_qual_off(data_qual_off), .data_strobe(data_strobe),
        .sel_flow(sel_flow), .sel_instr(sel_instr), .sel_stack(sel_stack),
        .sel_data(sel_data), .flow_en(flow_en), .instr_en(instr_en),
        .stack_en(stack_en), .data_en(data_en)
    );

    // Expected outputs from the requirements, and reference state update.
    task automatic predict();
        logic rise, on_a, off_a, qual, nxt, sub;
        logic [ND-1:0] dok;
        rise  = host_en & ~m_prev;
        on_a  = (|(exec_hit & exec_on_role))  | (|(data_hit & data_on_role));
        off_a = (|(exec_hit & exec_off_role)) | (|(data_hit & data_off_role));
        qual  = |(exec_hit & exec_qual_role);
        if (rise)          nxt = 1'b0;
        else if (!host_en) nxt = m_sect;
        else if (off_a)    nxt = 1'b0;
        else if (on_a)     nxt = 1'b1;
        else               nxt = m_sect;
        sub = nxt | qual;
        dok = data_hit & ((data_qual_on & {ND{sub}}) | (data_qual_off & {ND{~sub}}));
        e_flow  = host_en & sub & sel_flow;
        e_instr = host_en & sub & sel_instr;
        e_stack = host_en & sub & sel_stack;
        e_data  = host_en & sel_data & data_strobe & (|dok);
        m_sect  = nxt;
        m_prev  = host_en;
    endtask

    task automatic cmp(string tag, string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // Apply current inputs for one edge and compare at the following negedge.
    task automatic step(string tag);
        predict();
        @(posedge clk);
        @(negedge clk);
        cmp(tag, "flow_en",  flow_en,  e_flow);
        cmp(tag, "instr_en", instr_en, e_instr);
        cmp(tag, "stack_en", stack_en, e_stack);
        cmp(tag, "data_en",  data_en,  e_data);
    endtask

    task automatic idle();
        exec_hit = '0; data_hit = '0; data_strobe = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0; host_en = 1'b0;
        exec_hit = '0; exec_on_role = '0; exec_off_role = '0; exec_qual_role = '0;
        data_hit = '0; data_on_role = '0; data_off_role = '0;
        data_qual_on = '0; data_qual_off = '0; data_strobe = 1'b0;
        sel_flow = 1'b1; sel_instr = 1'b1; sel_stack = 1'b1; sel_data = 1'b1;
        m_sect = 1'b0; m_prev = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        cmp("R10", "flow_en",  flow_en,  1'b0);
        cmp("R10", "instr_en", instr_en, 1'b0);
        cmp("R10", "stack_en", stack_en, 1'b0);
        cmp("R10", "data_en",  data_en,  1'b0);
        rst_n = 1'b1;

        // Role setup: exec 0 on, exec 1 off, exec 2 qualify; data 0 on, data 1 off.
        exec_on_role = 8'h01; exec_off_role = 8'h02; exec_qual_role = 8'h04;
        data_on_role = 8'h01; data_off_role = 8'h02;

        // R1: events while disabled do nothing
        exec_hit = 8'h05; data_strobe = 1'b1; data_hit = 8'h10; data_qual_off = 8'h10;
        step("R1");
        idle();
        // R9: on-role hit in the rising cycle is ignored
        host_en = 1'b1; exec_hit = 8'h01;
        step("R9");
        idle(); step("R9");
        // R2: set by execution event, then stays latched
        exec_hit = 8'h01; step("R2");
        idle(); step("R2"); step("R2");
        // R3: clear by execution event
        exec_hit = 8'h02; step("R3");
        idle(); step("R3");
        // R2: set by data event
        data_hit = 8'h01; step("R2");
        idle();
        // R4: on and off together, off wins
        exec_hit = 8'h01; data_hit = 8'h02; step("R4");
        idle(); step("R4");
        // R5: qualify only while asserted
        exec_hit = 8'h04; step("R5");
        idle(); step("R5");
        // R7: individual selects
        exec_hit = 8'h01; sel_instr = 1'b0; step("R7");
        idle(); sel_flow = 1'b0; sel_instr = 1'b1; sel_stack = 1'b0; step("R7");
        sel_flow = 1'b1; sel_stack = 1'b1;
        // R8: data flags with the section set
        data_strobe = 1'b1; data_hit = 8'h30; data_qual_on = 8'h00; data_qual_off = 8'h30; step("R8");
        data_qual_on = 8'h10; step("R8");
        data_qual_on = 8'h30; data_qual_off = 8'h30; data_strobe = 1'b0; step("R8");
        // R8: with the section cleared
        exec_hit = 8'h02; data_strobe = 1'b1; data_hit = 8'h10; data_qual_on = 8'h10; data_qual_off = 8'h00; step("R8");
        exec_hit = 8'h00; data_qual_off = 8'h10; data_qual_on = 8'h00; step("R8");
        data_qual_on = 8'h10; step("R8");
        sel_data = 1'b0; step("R8");
        sel_data = 1'b1; idle();
        // R6: qualify OR section
        exec_hit = 8'h05; step("R6");
        exec_hit = 8'h06; step("R6");
        // R9: disable with section set, then re-enable clears it
        exec_hit = 8'h01; step("R9");
        idle(); host_en = 1'b0; step("R1");
        host_en = 1'b1; step("R9");
        exec_hit = 8'h04; host_en = 1'b0; step("R1");
        host_en = 1'b1; step("R9");
        idle(); step("R9");

        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            if (i % 64 == 0) begin
                exec_on_role   = 8'($urandom); exec_off_role = 8'($urandom) & 8'($urandom);
                exec_qual_role = 8'($urandom) & 8'($urandom);
                data_on_role   = 8'($urandom); data_off_role = 8'($urandom) & 8'($urandom);
                data_qual_on   = 8'($urandom); data_qual_off = 8'($urandom);
                sel_flow = 1'($urandom); sel_instr = 1'($urandom);
                sel_stack = 1'($urandom); sel_data = 1'($urandom);
            end
            if ($urandom % 40 == 0) host_en = ~host_en;
            exec_hit    = 8'($urandom) & 8'($urandom) & 8'($urandom);
            data_hit    = 8'($urandom) & 8'($urandom) & 8'($urandom);
            data_strobe = 1'($urandom);
            step("R6");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule